// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of sixteen lines managed through a small register port with a single-cycle request and a one-cycle-later ready. Each line is either an input or an output, chosen by a direction bit. An output line drives its latched value onto the pad while its output enable is active. An input line is brought into the clock domain through a synchronizer and can be masked on readback by a pin-control register.

Every input line can raise an interrupt on either a rising or a falling transition, picked by one polarity bit per line. An event sets a sticky status bit only when the line is an input and is not masked. Software clears status bits by writing ones to them. The single interrupt output stays high while any status bit is set.

Top module: `gpio16_edge_port`

## Requirements
- R1: After reset the output latch, direction, edge select, mask and pin-control registers read 0xFFFF, the status register and the input register read 0x0000, `irq` is 0 and `pin_oe` is 0x0000.
- R2: A read at offset 0x00 returns the synchronized input lines ANDed with the pin-control register. A pad change is visible there after two rising clock edges.
- R3: Direction is at offset 0x08 and the output latch at 0x04. A direction bit of 1 makes its line an input. `pin_oe` bit i equals the inverse of direction bit i. `pin_out` bit i carries latch bit i while the line is an output, and is 0 otherwise.
- R4: The edge select register is at offset 0x0C. Bit value 1 sets the status bit on a synchronized 0-to-1 transition, and bit value 0 sets it on a 1-to-0 transition. The status bit is set by the third rising clock edge after the pad changes.
- R5: The mask register is at offset 0x10. A status bit is set only when its direction bit is 1 and its mask bit is 0.
- R6: The status register is at offset 0x14. Writing ones clears the matching bits, and zeros leave bits unchanged. `irq` is 1 exactly while some status bit is 1. A new event in the same cycle as a clear of the same bit leaves the bit set.
- R7: Only accesses with `acc_full` = 1 (16-bit) take effect. A narrow write changes nothing, and a narrow read returns 0.
- R8: Writes to offset 0x00 are ignored. Offsets outside the seven mapped ones read 0 and ignore writes.
- R9: `ready` is 1 in the cycle after every cycle in which `req` is 1, and 0 otherwise. Read data is valid while `ready` is 1.
- R10: The pin-control register at offset 0x18 is readable and writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Register access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| acc_full | input | 1 | 1 = full 16-bit access |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, valid with ready |
| ready | output | 1 | Access completed |
| pin_in | input | WIDTH | Pad input levels, asynchronous |
| pin_out | output | WIDTH | Pad output levels |
| pin_oe | output | WIDTH | Pad output enables, 1 = drive |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The assertions take for granted that `addr`, `we`, `acc_full` and `wdata` are steady across the cycle in which `req` is sampled. They also assume that `irq` drops only because of a status-clear write and never through any other path. The bench drives every bus input and every pad at the falling clock edge, so the synchronizer input never changes at a sampling edge. Each access is held for exactly one rising edge. When the bench changes a pad while a test depends on that change, the mask is all ones or the timing is chosen on purpose, and every test ends by masking all lines and clearing the status register, so no event carries over into the next test.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

   localparam logic [7:0] OFS_IN     = 8'h00;
   localparam logic [7:0] OFS_OUT    = 8'h04;
   localparam logic [7:0] OFS_DIR    = 8'h08;
   localparam logic [7:0] OFS_EDGE   = 8'h0C;
   localparam logic [7:0] OFS_MASK   = 8'h10;
   localparam logic [7:0] OFS_STAT   = 8'h14;
   localparam logic [7:0] OFS_PINCTL = 8'h18;

   typedef enum logic [2:0] {
      SEL_IN,
      SEL_OUT,
      SEL_DIR,
      SEL_EDGE,
      SEL_MASK,
      SEL_STAT,
      SEL_PINCTL,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/gpio16_sync_chain.sv
module gpio16_sync_chain #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio16_sync_chain: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio16_edge_unit.sv
module gpio16_edge_unit #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] dir_in,
   input  logic [W-1:0] rise_sel,
   input  logic [W-1:0] mask,
   output logic [W-1:0] hit
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall, event_v;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   assign rise    = cur & ~prev_q;
   assign fall    = ~cur & prev_q;
   assign event_v = (rise_sel & rise) | (~rise_sel & fall);
   assign hit     = event_v & dir_in & ~mask;
endmodule

// File: rtl/gpio16_reg_bank.sv
module gpio16_reg_bank
   import gpio16_pkg::*;
#(
   parameter int W      = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic              acc_full,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   input  logic [W-1:0]      line_in,
   input  logic [W-1:0]      hit,
   output logic [W-1:0]      out_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      edge_q,
   output logic [W-1:0]      mask_q,
   output logic              irq,
   output logic [W-1:0]      rdata,
   output logic              ready
);
   logic [W-1:0] stat_q, pinctl_q;
   logic [W-1:0] clr_v, rd_v;
   reg_sel_e     sel;
   logic         wr_ok, rd_ok;

   always_comb begin
      if      (addr == ADDR_W'(OFS_IN))     sel = SEL_IN;
      else if (addr == ADDR_W'(OFS_OUT))    sel = SEL_OUT;
      else if (addr == ADDR_W'(OFS_DIR))    sel = SEL_DIR;
      else if (addr == ADDR_W'(OFS_EDGE))   sel = SEL_EDGE;
      else if (addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
      else if (addr == ADDR_W'(OFS_STAT))   sel = SEL_STAT;
      else if (addr == ADDR_W'(OFS_PINCTL)) sel = SEL_PINCTL;
      else                                  sel = SEL_NONE;
   end

   assign wr_ok = req & we & acc_full;
   assign rd_ok = req & ~we & acc_full;
   assign clr_v = (wr_ok && sel == SEL_STAT) ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q    <= '1;
         dir_q    <= '1;
         edge_q   <= '1;
         mask_q   <= '1;
         pinctl_q <= '1;
      end else if (wr_ok) begin
         case (sel)
            SEL_OUT:    out_q    <= wdata;
            SEL_DIR:    dir_q    <= wdata;
            SEL_EDGE:   edge_q   <= wdata;
            SEL_MASK:   mask_q   <= wdata;
            SEL_PINCTL: pinctl_q <= wdata;
            default: ;
         endcase
      end
   end

   // New events win over a clear of the same bit in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_v) | hit;
   end

   assign irq = |stat_q;

   always_comb begin
      case (sel)
         SEL_IN:     rd_v = line_in & pinctl_q;
         SEL_OUT:    rd_v = out_q;
         SEL_DIR:    rd_v = dir_q;
         SEL_EDGE:   rd_v = edge_q;
         SEL_MASK:   rd_v = mask_q;
         SEL_STAT:   rd_v = stat_q;
         SEL_PINCTL: rd_v = pinctl_q;
         default:    rd_v = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready <= 1'b0;
         rdata <= '0;
      end else begin
         ready <= req;
         if (req) rdata <= rd_ok ? rd_v : '0;
      end
   end
endmodule

// File: rtl/gpio16_edge_port.sv
module gpio16_edge_port #(
   parameter int WIDTH       = 16,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic              acc_full,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   output logic              ready,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic              irq
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio16_edge_port: WIDTH must be 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio16_edge_port: ADDR_W must reach offset 0x18");
   end

   logic [WIDTH-1:0] line_sync, hit;
   logic [WIDTH-1:0] out_q, dir_q, edge_q, mask_q;

   gpio16_sync_chain #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(line_sync)
   );

   gpio16_edge_unit #(.W(WIDTH)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur(line_sync), .dir_in(dir_q),
      .rise_sel(edge_q), .mask(mask_q), .hit(hit)
   );

   gpio16_reg_bank #(.W(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .acc_full(acc_full),
      .addr(addr), .wdata(wdata), .line_in(line_sync), .hit(hit),
      .out_q(out_q), .dir_q(dir_q), .edge_q(edge_q), .mask_q(mask_q),
      .irq(irq), .rdata(rdata), .ready(ready)
   );

   assign pin_oe  = ~dir_q;
   assign pin_out = out_q & ~dir_q;
endmodule

// File: rtl/gpio16_edge_port_chk.sv
module gpio16_edge_port_chk #(
   parameter int W      = 16,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              we,
   input logic              acc_full,
   input logic [ADDR_W-1:0] addr,
   input logic [W-1:0]      wdata,
   input logic              ready,
   input logic [W-1:0]      pin_out,
   input logic [W-1:0]      pin_oe,
   input logic              irq
);
   localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(8'h08);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h14);

   a_r9_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ready);

   a_r9_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ready);

   a_r3_oe_follows_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && acc_full && addr == A_DIR) |=> (pin_oe == ~$past(wdata)));

   a_r7_narrow_dir_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && !acc_full && addr == A_DIR) |=> $stable(pin_oe));

   a_r6_irq_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(req && we && acc_full && addr == A_STAT));

   a_r8_input_write_no_pin_change: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && addr == A_IN) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio16_edge_port gpio16_edge_port_chk #(.W(WIDTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .we(we), .acc_full(acc_full),
   .addr(addr), .wdata(wdata), .ready(ready), .pin_out(pin_out),
   .pin_oe(pin_oe), .irq(irq)
);

// File: tb/tb_gpio16_edge_port.sv
`timescale 1ns/1ps
module tb_gpio16_edge_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, acc_full = 1'b1;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
   logic        ready, irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   gpio16_edge_port dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .acc_full(acc_full),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic full = 1'b1);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; wdata = d; acc_full = full;
      @(negedge clk);
      req = 1'b0; we = 1'b0; acc_full = 1'b1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d, input logic full = 1'b1);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a; acc_full = full;
      @(negedge clk);
      chk("R9 ready after request", {15'b0, ready}, 16'h0001);
      d = rdata;
      req = 1'b0; acc_full = 1'b1;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic tidy();
      wr(8'h10, 16'hFFFF);
      wr(8'h14, 16'hFFFF);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R1 irq at reset", {15'b0, irq}, 16'h0000);
      chk("R1 pin_oe at reset", pin_oe, 16'h0000);
      rd(8'h00, v); chk("R1 input reg", v, 16'h0000);
      rd(8'h04, v); chk("R1 output latch", v, 16'hFFFF);
      rd(8'h08, v); chk("R1 direction", v, 16'hFFFF);
      rd(8'h0C, v); chk("R1 edge select", v, 16'hFFFF);
      rd(8'h10, v); chk("R1 mask", v, 16'hFFFF);
      rd(8'h14, v); chk("R1 status", v, 16'h0000);
      rd(8'h18, v); chk("R1 pin control", v, 16'hFFFF);
      @(negedge clk);
      chk("R9 ready low when idle", {15'b0, ready}, 16'h0000);
   endtask

   task automatic t_input_and_pinctl();
      logic [15:0] v;
      @(negedge clk); pin_in = 16'hA5C3;
      settle();
      rd(8'h00, v); chk("R2 input readback", v, 16'hA5C3);
      wr(8'h18, 16'h00FF);
      rd(8'h18, v); chk("R10 pin control readback", v, 16'h00FF);
      rd(8'h00, v); chk("R2 input masked by pin control", v, 16'h00C3);
      wr(8'h18, 16'hFFFF);
      @(negedge clk); pin_in = 16'h0000;
      settle();
   endtask

   task automatic t_dir_out();
      wr(8'h04, 16'h1234);
      chk("R3 no drive while all inputs", pin_out, 16'h0000);
      wr(8'h08, 16'hFF00);
      chk("R3 output enables", pin_oe, 16'h00FF);
      chk("R3 driven output values", pin_out, 16'h0034);
      wr(8'h08, 16'hFFFF);
      chk("R3 enables drop", pin_oe, 16'h0000);
   endtask

   task automatic t_edges();
      logic [15:0] v;
      wr(8'h10, 16'hFFFE);
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R4 status not yet set at edge 2", {15'b0, irq}, 16'h0000);
      @(negedge clk);
      chk("R4 rising edge raises irq at edge 3", {15'b0, irq}, 16'h0001);
      rd(8'h14, v); chk("R4 rising edge status", v, 16'h0001);
      wr(8'h14, 16'h0001);
      chk("R6 irq drops after clear", {15'b0, irq}, 16'h0000);
      @(negedge clk); pin_in[0] = 1'b0;
      settle();
      rd(8'h14, v); chk("R4 falling ignored with rising select", v, 16'h0000);
      wr(8'h0C, 16'hFFFE);
      @(negedge clk); pin_in[0] = 1'b1;
      settle();
      rd(8'h14, v); chk("R4 rising ignored with falling select", v, 16'h0000);
      @(negedge clk); pin_in[0] = 1'b0;
      settle();
      rd(8'h14, v); chk("R4 falling edge status", v, 16'h0001);
      wr(8'h0C, 16'hFFFF);
      tidy();
   endtask

   task automatic t_gating();
      logic [15:0] v;
      @(negedge clk); pin_in[1] = 1'b1;
      settle();
      rd(8'h14, v); chk("R5 masked line sets nothing", v, 16'h0000);
      @(negedge clk); pin_in[1] = 1'b0;
      settle();
      wr(8'h08, 16'hFFFD);
      wr(8'h10, 16'hFFFD);
      @(negedge clk); pin_in[1] = 1'b1;
      settle();
      rd(8'h14, v); chk("R5 output line sets nothing", v, 16'h0000);
      chk("R5 irq stays low", {15'b0, irq}, 16'h0000);
      wr(8'h08, 16'hFFFF);
      @(negedge clk); pin_in[1] = 1'b0;
      settle();
      tidy();
   endtask

   task automatic t_partial_clear();
      logic [15:0] v;
      wr(8'h10, 16'hFFFC);
      @(negedge clk); pin_in[1:0] = 2'b11;
      settle();
      rd(8'h14, v); chk("R6 two events", v, 16'h0003);
      wr(8'h14, 16'h0001);
      rd(8'h14, v); chk("R6 partial clear", v, 16'h0002);
      chk("R6 irq held by remaining bit", {15'b0, irq}, 16'h0001);
      wr(8'h14, 16'h0002);
      chk("R6 irq low when all clear", {15'b0, irq}, 16'h0000);
      @(negedge clk); pin_in[1:0] = 2'b00;
      settle();
      rd(8'h14, v); chk("R6 falling ignored", v, 16'h0000);
      tidy();
   endtask

   task automatic t_set_over_clear();
      logic [15:0] v;
      wr(8'h10, 16'hFFFE);
      @(negedge clk); pin_in[0] = 1'b1;
      settle();
      @(negedge clk); pin_in[0] = 1'b0;
      settle();
      rd(8'h14, v); chk("R6 bit set before race", v, 16'h0001);
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 8'h14; wdata = 16'h0001; acc_full = 1'b1;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      rd(8'h14, v); chk("R6 event wins over same-cycle clear", v, 16'h0001);
      @(negedge clk); pin_in[0] = 1'b0;
      settle();
      tidy();
   endtask

   task automatic t_narrow();
      logic [15:0] v;
      wr(8'h08, 16'h0F0F, 1'b0);
      chk("R7 narrow write ignored", pin_oe, 16'h0000);
      rd(8'h08, v, 1'b0); chk("R7 narrow read returns zero", v, 16'h0000);
      rd(8'h08, v); chk("R7 full read still works", v, 16'hFFFF);
   endtask

   task automatic t_ro_unmapped();
      logic [15:0] v;
      @(negedge clk); pin_in = 16'h5A5A;
      settle();
      wr(8'h00, 16'h0000);
      rd(8'h00, v); chk("R8 input write ignored", v, 16'h5A5A);
      wr(8'h1C, 16'h1234);
      rd(8'h1C, v); chk("R8 unmapped reads zero", v, 16'h0000);
      rd(8'h04, v); chk("R8 unmapped write left latch", v, 16'h1234);
      rd(8'h14, v); chk("R8 status unchanged", v, 16'h0000);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_input_and_pinctl();
      t_dir_out();
      t_edges();
      t_gating();
      t_partial_clear();
      t_set_over_clear();
      t_narrow();
      t_ro_unmapped();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule